// File: doc/BRIEF.md
# Special Register Write Unit

This block carries out the register-write half of a move-to-special-register operation in a small microcontroller core. Each write arrives as a 12-bit control field and a 32-bit source word. The low byte of the control field picks the destination. The top nibble is a write mask that chooses which groups of application flags may change. The unit keeps the combined program status word and updates only the flag bits it is allowed to touch. It also sends stack pointer writes out as strobes with an aligned value.

Privilege is checked first. An unprivileged write may reach only the status views, selectors 0 to 7, and any other write from unprivileged code is dropped without a trace. A strap input tells the unit whether the signal-processing extension is built in; when it is absent, the greater-or-equal flags cannot be written. Mask and selector combinations that have no defined meaning raise no fault: the mask bits are applied exactly as given.

Top module: `sreg_write_unit`

## Requirements
- R1: After reset `statusWord` reads 0 and both stack strobes are low.
- R2: On a cycle with `wrValid` high, the selector is `ctrlField[7:0]` and the mask is `ctrlField[11:8]`.
- R3: A status write (selector 0..7 with selector bit 2 clear) whose mask bit 3 is set loads `statusWord[31:27]` from `wrData[31:27]` at the next clock edge.
- R4: A status write whose mask bit 2 is set loads `statusWord[19:16]` from `wrData[19:16]` at the next clock edge, but only while `dspPresent` is 1.
- R5: Status bits not enabled by R3/R4 keep their value; bits outside [31:27] and [19:16] never change.
- R6: Selectors 0..7 with selector bit 2 set leave `statusWord` unchanged whatever the mask.
- R7: Selector 8 produces a one-cycle `mspWrStrobe` on the cycle after the write, with `spWrValue` equal to `wrData` with bits [1:0] cleared; selector 9 does the same on `pspWrStrobe`.
- R8: When `privileged` is 0 and the selector is above 7, nothing changes: no strobe fires and `statusWord` holds.
- R9: Other selectors above 9 have no effect, and no combination raises an error; undefined mask combinations are applied as given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write request this cycle |
| ctrlField | input | 12 | Mask [11:8], selector [7:0] |
| wrData | input | 32 | Source value |
| privileged | input | 1 | 1 = privileged execution |
| dspPresent | input | 1 | Strap: signal-processing extension present |
| statusWord | output | 32 | Current combined status word |
| mspWrStrobe | output | 1 | Main stack pointer write strobe |
| pspWrStrobe | output | 1 | Process stack pointer write strobe |
| spWrValue | output | 32 | Word-aligned stack pointer value |

## Verification
All sixteen mask values are driven on status selectors with the strap both on and off. This shows that the flag group and the greater-or-equal group are enabled independently and that the strap gates only the second group. The bench also sends writes to the views with selector bit 2 set, and to the stack selectors and out-of-range selectors at both privilege levels. These cases separate a blocked write from a forwarded one. Random writes with random data, selectors and privilege follow, so that retention of the untouched bits is checked against a model built in the bench.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int CTRL_W = 12;
  localparam int DATA_W = 32;
  localparam int SEL_W = 8;
  localparam int MASK_W = 4;
  localparam logic [SEL_W-1:0] SEL_MSP = 8'd8;
  localparam logic [SEL_W-1:0] SEL_PSP = 8'd9;
  localparam logic [DATA_W-1:0] FLAG_BITS = 32'hF800_0000;
  localparam logic [DATA_W-1:0] GE_BITS = 32'h000F_0000;

  typedef struct packed {
    logic flagWr;
    logic geWr;
    logic mspWr;
    logic pspWr;
  } sregStrobes_t;
endpackage

// File: rtl/sreg_ctrl.sv
module sreg_ctrl
  import sreg_pkg::*;
(
  input  logic               wrValid,
  input  logic [CTRL_W-1:0]  ctrlField,
  input  logic               privileged,
  input  logic               dspPresent,
  output sregStrobes_t       strobes
);
  logic [SEL_W-1:0]  sel;
  logic [MASK_W-1:0] mask;
  logic              statusSel;
  logic              blocked;

  assign sel  = ctrlField[SEL_W-1:0];
  assign mask = ctrlField[CTRL_W-1:SEL_W];
  assign statusSel = (sel <= 8'd7);
  assign blocked = !privileged && !statusSel;

  always_comb begin
    strobes = '0;
    if (wrValid && !blocked) begin
      if (statusSel && !sel[2]) begin
        strobes.flagWr = mask[3];
        strobes.geWr   = mask[2] && dspPresent;
      end
      strobes.mspWr = (sel == SEL_MSP);
      strobes.pspWr = (sel == SEL_PSP);
    end
  end
endmodule

// File: rtl/sreg_datapath.sv
module sreg_datapath
  import sreg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  sregStrobes_t       strobes,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  statusWord,
  output logic               mspWrStrobe,
  output logic               pspWrStrobe,
  output logic [DATA_W-1:0]  spWrValue
);
  logic [DATA_W-1:0] bitEn;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_bitEn
      assign bitEn[i] = (FLAG_BITS[i] & strobes.flagWr) | (GE_BITS[i] & strobes.geWr);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusWord  <= '0;
      mspWrStrobe <= 1'b0;
      pspWrStrobe <= 1'b0;
      spWrValue   <= '0;
    end else begin
      statusWord  <= (statusWord & ~bitEn) | (wrData & bitEn);
      mspWrStrobe <= strobes.mspWr;
      pspWrStrobe <= strobes.pspWr;
      if (strobes.mspWr || strobes.pspWr)
        spWrValue <= {wrData[DATA_W-1:2], 2'b00};
    end
  end
endmodule

// File: rtl/sreg_write_unit.sv
module sreg_write_unit
  import sreg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  logic [11:0] ctrlField,
  input  logic [31:0] wrData,
  input  logic        privileged,
  input  logic        dspPresent,
  output logic [31:0] statusWord,
  output logic        mspWrStrobe,
  output logic        pspWrStrobe,
  output logic [31:0] spWrValue
);
  sregStrobes_t strobes;

  sreg_ctrl u_ctrl (
    .wrValid(wrValid), .ctrlField(ctrlField), .privileged(privileged),
    .dspPresent(dspPresent), .strobes(strobes)
  );

  sreg_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .statusWord(statusWord), .mspWrStrobe(mspWrStrobe),
    .pspWrStrobe(pspWrStrobe), .spWrValue(spWrValue)
  );
endmodule

// File: rtl/sreg_write_unit_chk.sv
module sreg_write_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrValid,
  input logic [11:0] ctrlField,
  input logic [31:0] wrData,
  input logic        privileged,
  input logic        dspPresent,
  input logic [31:0] statusWord,
  input logic        mspWrStrobe,
  input logic        pspWrStrobe,
  input logic [31:0] spWrValue
);
  // R5
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statusWord & 32'h07F0_FFFF) == 32'h0));
  // R7
  sp_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mspWrStrobe || pspWrStrobe) |-> (spWrValue[1:0] == 2'b00));
  // R7
  sp_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({mspWrStrobe, pspWrStrobe}) <= 1);
  // R8
  unpriv_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !privileged && ctrlField[7:0] > 8'd7) |=> (!mspWrStrobe && !pspWrStrobe && $stable(statusWord)));
  // R4
  ge_strap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dspPresent) |=> (statusWord[19:16] == $past(statusWord[19:16])));
  // R6
  readonly_view_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && ctrlField[7:0] <= 8'd7 && ctrlField[2]) |=> $stable(statusWord));
  // R7
  msp_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && privileged && ctrlField[7:0] == 8'd8) |=> (mspWrStrobe && spWrValue == {$past(wrData[31:2]), 2'b00}));
endmodule

bind sreg_write_unit sreg_write_unit_chk u_chk (.*);

// File: tb/sreg_write_unit_tb.sv
module sreg_write_unit_tb;
  logic clk = 0, rstN = 0, wrValid = 0, privileged = 1, dspPresent = 1;
  logic [11:0] ctrlField = '0;
  logic [31:0] wrData = '0;
  logic [31:0] statusWord, spWrValue;
  logic mspWrStrobe, pspWrStrobe;
  int checks = 0, fails = 0;
  logic [31:0] model = '0;

  always #2.5 clk = ~clk;

  sreg_write_unit u_dut (.*);

  function automatic logic [31:0] nextStatus(logic [31:0] cur, logic [11:0] cf,
      logic [31:0] d, logic pv, logic dsp);
    logic [31:0] en = 0;
    if (cf[7:0] <= 8'd7 && !cf[2]) begin
      if (cf[11]) en |= 32'hF800_0000;
      if (cf[10] && dsp) en |= 32'h000F_0000;
    end
    return (cur & ~en) | (d & en);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one write, sample at the negedge after the capturing posedge
  task automatic doWrite(logic [11:0] cf, logic [31:0] d, logic pv, logic dsp);
    @(negedge clk);
    ctrlField = cf; wrData = d; privileged = pv; dspPresent = dsp; wrValid = 1;
    model = nextStatus(model, cf, d, pv, dsp);
    @(negedge clk);
    wrValid = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 status", statusWord, 0);
    chk("R1 strobes", {30'b0, mspWrStrobe, pspWrStrobe}, 0);

    // every mask, strap on and off
    for (int dsp = 0; dsp < 2; dsp++)
      for (int m = 0; m < 16; m++) begin
        logic [31:0] d = $urandom;
        doWrite({m[3:0], 8'd0}, d, 1'b1, dsp[0]);
        chk($sformatf("R3 R4 R5 mask=%0d dsp=%0d", m, dsp), statusWord, model);
        doWrite({m[3:0], 8'd3}, ~d, 1'b0, dsp[0]);
        chk($sformatf("R2 R3 unpriv view mask=%0d", m), statusWord, model);
      end

    // R6: read-only views
    for (int s = 4; s < 8; s++) begin
      doWrite({4'hF, s[7:0]}, 32'hFFFF_FFFF ^ model, 1'b1, 1'b1);
      chk("R6 ro view", statusWord, model);
    end

    // R7 stack pointers
    doWrite({4'h0, 8'd8}, 32'h2000_1237, 1'b1, 1'b1);
    chk("R7 msp strobe", {30'b0, mspWrStrobe, pspWrStrobe}, 32'h2);
    chk("R7 msp value", spWrValue, 32'h2000_1234);
    @(negedge clk);
    chk("R7 msp one cycle", {31'b0, mspWrStrobe}, 0);
    doWrite({4'h8, 8'd9}, 32'h1000_FFFF, 1'b1, 1'b1);
    chk("R7 psp strobe", {30'b0, mspWrStrobe, pspWrStrobe}, 32'h1);
    chk("R7 psp value", spWrValue, 32'h1000_FFFC);
    chk("R7 status untouched", statusWord, model);

    // R8 unprivileged to sp
    doWrite({4'hF, 8'd8}, 32'hAAAA_AAAA, 1'b0, 1'b1);
    chk("R8 msp blocked", {30'b0, mspWrStrobe, pspWrStrobe}, 0);
    chk("R8 status", statusWord, model);
    doWrite({4'hC, 8'd9}, 32'h5555_5555, 1'b0, 1'b1);
    chk("R8 psp blocked", {30'b0, mspWrStrobe, pspWrStrobe}, 0);

    // R9 other selectors
    doWrite({4'hF, 8'd10}, 32'hFFFF_FFFF, 1'b1, 1'b1);
    chk("R9 sel10", {mspWrStrobe, pspWrStrobe, statusWord[29:0]}, {2'b0, model[29:0]});
    doWrite({4'hF, 8'd255}, 32'hFFFF_FFFF, 1'b1, 1'b1);
    chk("R9 sel255", statusWord, model);

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [11:0] cf = $urandom;
      logic [31:0] d = $urandom;
      logic pv = $urandom;
      logic dsp = $urandom;
      logic [7:0] sel;
      if ($urandom % 2) cf[7:0] = 8'($urandom % 12);
      sel = cf[7:0];
      doWrite(cf, d, pv, dsp);
      chk("R5 R8 random status", statusWord, model);
      chk("R7 R8 random strobes", {30'b0, mspWrStrobe, pspWrStrobe},
          {30'b0, pv && sel == 8'd8, pv && sel == 8'd9});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule